// File: doc/BRIEF.md
# External Interrupt Edge and Level Detector

This block watches sixteen external interrupt lines, grouped as four ports of four pins. Every pin has a 2-bit detection mode that decides which input activity raises its request: a falling edge, a rising edge, a low level, or either edge. The detected request is held in a per-pin flag until the processor acknowledges that pin or software wipes the flag with a clear mask. All sixteen flags are presented together as one word.

Each line first crosses into the clock domain through a two-stage synchroniser. It is then sampled only on every second system clock. Edges are found by comparing each new sample with the one before it. The modes live in four byte-wide mode registers, one per port, written and read through a small register port that selects the port with a 2-bit index. In low-level mode a flag sets again on the next sample after a clear for as long as the line stays low. A low-level request that was caught and then released stays latched until it is serviced.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset every flag reads 0 and every mode register reads 00h, so each pin starts in falling-edge mode (code 00).
- R2: Writing `cfg_wdata` with `cfg_we` high stores it in the mode register chosen by `cfg_port`. `cfg_rdata` returns the register chosen by `cfg_port` unchanged, and the other three registers keep their values. Global pin 4p+m uses bits [2m+1:2m] of the register of port p.
- R3: Mode code 00 sets the pin's flag when a high sample is followed by a low sample.
- R4: Mode code 01 sets the pin's flag when a low sample is followed by a high sample, and does not set it on a high-to-low change.
- R5: Mode code 10 sets the flag on every sample that reads low. If the flag is cleared while the line is still low, it sets again.
- R6: Mode code 11 sets the flag on both a high-to-low and a low-to-high change, but not while the line rests at either level.
- R7: In mode 10, a flag that was set stays set after the line returns high, until it is acknowledged or cleared.
- R8: A one-cycle `ack_valid` strobe clears only the flag numbered by `ack_idx`.
- R9: Each bit set in the one-cycle `sw_clr` mask clears the matching flag. Flags whose bits are not set are left alone.
- R10: Lines are sampled once every two clock cycles. A low pulse one clock long is therefore caught by at most one of two consecutive sample phases.
- R11: When a set condition and a clear reach a flag in the same cycle, the flag ends set.
- R12: A mode write never sets a flag by itself. The stored previous sample of the written port's pins is reloaded from the current line level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Asynchronous external interrupt lines, global pin index 4p+m |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_port | input | 2 | Port index for both the write and the read-back |
| cfg_wdata | input | 8 | Mode register write data, four 2-bit fields |
| cfg_rdata | output | 8 | Read-back of the mode register chosen by `cfg_port` |
| ack_valid | input | 1 | Acknowledge strobe for one pin |
| ack_idx | input | 4 | Global pin index being acknowledged |
| sw_clr | input | 16 | Software clear mask, one bit per flag |
| req_flags | output | 16 | Latched request flags |

## Verification
The bench sweeps every pin through all four mode codes. Each pass applies the same sequence: fall, clear while low, rise, acknowledge. From the flag word after each step the bench can tell falling, rising, level and both-edge detection apart, and can confirm that a level request re-asserts and stays pending. Two single-cycle low pulses on neighbouring pins in consecutive cycles show that sampling happens every other cycle, since exactly one of the pulses may land. A clear held across an edge shows whether set or clear wins. Back-to-back mode rewrites on a line held low show that a mode change creates no false edge.

// File: rtl/irq_det_pkg.sv
// Shared definitions for the external interrupt detector.
// Assumes a 2-bit mode field per pin; the codes below are decoded by
// every pin detector and must not be reordered.
package irq_det_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        DET_FALL = 2'b00,
        DET_RISE = 2'b01,
        DET_LOW  = 2'b10,
        DET_BOTH = 2'b11
    } det_mode_e;

endpackage

// File: rtl/irq_in_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous lines.
// Each bit is treated on its own; no relation between bits is kept.
// Assumes idle lines are high, so the chain resets to RST_VAL.
module irq_in_sync #(
    parameter int       WIDTH   = 16,
    parameter int       STAGES  = 2,
    parameter bit       RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the chain per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= {WIDTH{RST_VAL}};
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/irq_sample_timer.sv
// Produces a one-cycle sample strobe every DIV system clocks.
// Assumes DIV >= 1; DIV of 1 strobes on every cycle.
module irq_sample_timer #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CNT_W = $clog2(DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
            logic [CNT_W-1:0] cnt;

            // Count system clocks and wrap at DIV.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/irq_mode_bank.sv
// Bank of per-port mode registers.
// Writes one port register per strobe; reads back the indexed register
// combinationally. Also flags, per pin, which pins a write touches so the
// detectors can resynchronise their stored sample.
module irq_mode_bank #(
    parameter int NUM_PORTS     = 4,
    parameter int PINS_PER_PORT = 4,
    parameter int MODE_W        = 2
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    wr_en,
    input  logic [$clog2(NUM_PORTS)-1:0]            port_sel,
    input  logic [PINS_PER_PORT*MODE_W-1:0]         wr_data,
    output logic [PINS_PER_PORT*MODE_W-1:0]         rd_data,
    output logic [NUM_PORTS*PINS_PER_PORT*MODE_W-1:0] mode_flat,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]      pin_wr
);

    localparam int REG_W = PINS_PER_PORT * MODE_W;

    logic [REG_W-1:0] regs [NUM_PORTS];

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            logic hit;
            assign hit = wr_en && (port_sel == ($clog2(NUM_PORTS))'(p));

            // Hold the mode register of port p; load it on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[p] <= '0;
                end else if (hit) begin
                    regs[p] <= wr_data;
                end
            end

            assign mode_flat[p*REG_W +: REG_W]                 = regs[p];
            assign pin_wr[p*PINS_PER_PORT +: PINS_PER_PORT]    = {PINS_PER_PORT{hit}};
        end
    endgenerate

    // Return the register chosen by the port index.
    always_comb begin
        rd_data = regs[port_sel];
    end

endmodule

// File: rtl/irq_pin_detect.sv
// Detector and request flag for one interrupt pin.
// On each sample strobe it compares the synchronised level with the
// previous sample under the pin's mode. A set beats a clear in the same
// cycle. A mode write reloads the previous sample and suppresses detection
// for that cycle. Assumes lines idle high.
module irq_pin_detect
    import irq_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    input  logic              resync,
    input  logic              clr,
    output logic              flag
);

    logic      last;
    logic      hit;
    logic      set_now;
    det_mode_e md;

    assign md = det_mode_e'(mode);

    // Decide whether the present level, against the last sample, is an event.
    always_comb begin
        unique case (md)
            DET_FALL: hit = last & ~lvl;
            DET_RISE: hit = ~last & lvl;
            DET_LOW:  hit = ~lvl;
            DET_BOTH: hit = last ^ lvl;
            default:  hit = 1'b0;
        endcase
    end

    assign set_now = tick && !resync && hit;

    // Keep the previous sample; reload on strobes and on mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last <= 1'b1;
        end else if (tick || resync) begin
            last <= lvl;
        end
    end

    // Latch the request flag; set has priority over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_now) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ext_irq_detect.sv
// Top of the external interrupt detector.
// Synchronises the lines, generates the divided sample strobe, holds the
// mode registers and instantiates one detector per pin. The acknowledge
// index and the software mask are merged into a per-pin clear.
module ext_irq_detect #(
    parameter int NUM_PORTS     = 4,
    parameter int PINS_PER_PORT = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int SAMPLE_DIV    = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]            irq_lines,
    input  logic                                          cfg_we,
    input  logic [$clog2(NUM_PORTS)-1:0]                  cfg_port,
    input  logic [PINS_PER_PORT*irq_det_pkg::MODE_W-1:0]  cfg_wdata,
    output logic [PINS_PER_PORT*irq_det_pkg::MODE_W-1:0]  cfg_rdata,
    input  logic                                          ack_valid,
    input  logic [$clog2(NUM_PORTS*PINS_PER_PORT)-1:0]    ack_idx,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0]            sw_clr,
    output logic [NUM_PORTS*PINS_PER_PORT-1:0]            req_flags
);

    import irq_det_pkg::*;

    localparam int NPIN   = NUM_PORTS * PINS_PER_PORT;
    localparam int PIN_AW = $clog2(NPIN);

    logic [NPIN-1:0]        lvl_sync;
    logic                   sample_tick;
    logic [NPIN*MODE_W-1:0] mode_flat;
    logic [NPIN-1:0]        pin_wr;
    logic [NPIN-1:0]        pin_clr;

    irq_in_sync #(
        .WIDTH   (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_lines),
        .sync_out (lvl_sync)
    );

    irq_sample_timer #(
        .DIV (SAMPLE_DIV)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick)
    );

    irq_mode_bank #(
        .NUM_PORTS     (NUM_PORTS),
        .PINS_PER_PORT (PINS_PER_PORT),
        .MODE_W        (MODE_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .port_sel  (cfg_port),
        .wr_data   (cfg_wdata),
        .rd_data   (cfg_rdata),
        .mode_flat (mode_flat),
        .pin_wr    (pin_wr)
    );

    genvar i;
    generate
        for (i = 0; i < NPIN; i++) begin : g_pin
            // Merge the acknowledge strobe and the software mask for pin i.
            assign pin_clr[i] = sw_clr[i] | (ack_valid && (ack_idx == PIN_AW'(i)));

            irq_pin_detect u_det (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (sample_tick),
                .lvl    (lvl_sync[i]),
                .mode   (mode_flat[i*MODE_W +: MODE_W]),
                .resync (pin_wr[i]),
                .clr    (pin_clr[i]),
                .flag   (req_flags[i])
            );
        end
    endgenerate

endmodule

// File: rtl/ext_irq_detect_chk.sv
// Assertion checker for ext_irq_detect, attached by bind below.
// Watches the ports plus the internal sample strobe and mode bus.
module ext_irq_detect_chk #(
    parameter int NPIN    = 16,
    parameter int REG_W   = 8,
    parameter int PORT_AW = 2,
    parameter int PIN_AW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    cfg_we,
    input  logic [PORT_AW-1:0]      cfg_port,
    input  logic [REG_W-1:0]        cfg_wdata,
    input  logic [NPIN/ (REG_W/2) * REG_W - 1:0] mode_flat,
    input  logic                    ack_valid,
    input  logic [PIN_AW-1:0]       ack_idx,
    input  logic [NPIN-1:0]         sw_clr,
    input  logic [NPIN-1:0]         req_flags
);

    logic [PORT_AW-1:0] wr_port_q;
    logic [REG_W-1:0]   wr_data_q;
    logic [PIN_AW-1:0]  ack_idx_q;
    logic               ack_q;
    logic [NPIN-1:0]    clr_q;
    logic [NPIN-1:0]    flags_q;
    logic               tick_q;
    logic [REG_W-1:0]   wr_slice;

    // Remember last-cycle inputs and outputs for the properties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_port_q <= '0;
            wr_data_q <= '0;
            ack_idx_q <= '0;
            ack_q     <= 1'b0;
            clr_q     <= '0;
            flags_q   <= '0;
            tick_q    <= 1'b0;
        end else begin
            wr_port_q <= cfg_port;
            wr_data_q <= cfg_wdata;
            ack_idx_q <= ack_idx;
            ack_q     <= ack_valid;
            clr_q     <= sw_clr;
            flags_q   <= req_flags;
            tick_q    <= tick;
        end
    end

    assign wr_slice = mode_flat[int'(wr_port_q)*REG_W +: REG_W];

    a_r1_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (req_flags == '0));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (wr_slice == wr_data_q));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !tick) |=> (req_flags[ack_idx_q] == 1'b0));

    a_r9_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sw_clr) && !tick) |=> ((req_flags & clr_q) == '0));

    a_r10_set_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_flags & ~flags_q)) |-> tick_q);

    a_r9_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_q & ~req_flags)) |-> ((clr_q != '0) || ack_q));

endmodule

bind ext_irq_detect ext_irq_detect_chk #(
    .NPIN    (NUM_PORTS * PINS_PER_PORT),
    .REG_W   (PINS_PER_PORT * irq_det_pkg::MODE_W),
    .PORT_AW ($clog2(NUM_PORTS)),
    .PIN_AW  ($clog2(NUM_PORTS * PINS_PER_PORT))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .cfg_we    (cfg_we),
    .cfg_port  (cfg_port),
    .cfg_wdata (cfg_wdata),
    .mode_flat (mode_flat),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .sw_clr    (sw_clr),
    .req_flags (req_flags)
);

// File: tb/ext_irq_detect_bench.sv
module ext_irq_detect_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = 16'hFFFF;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_port = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_idx = 4'd0;
    logic [15:0] sw_clr = 16'h0000;
    logic [15:0] req_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ext_irq_detect u_ext_irq_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .cfg_we    (cfg_we),
        .cfg_port  (cfg_port),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .sw_clr    (sw_clr),
        .req_flags (req_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] port, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = port; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_mode(input logic [1:0] port, output logic [7:0] data);
        @(negedge clk);
        cfg_port = port;
        #1 data = cfg_rdata;
    endtask

    task automatic pulse_clr(input logic [15:0] mask);
        @(negedge clk);
        sw_clr = mask;
        @(negedge clk);
        sw_clr = '0;
    endtask

    task automatic pulse_ack(input logic [3:0] idx);
        @(negedge clk);
        ack_valid = 1'b1; ack_idx = idx;
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    function automatic string mode_tag(input int md);
        case (md)
            0: return "R3 falling";
            1: return "R4 rising";
            2: return "R5 low-level";
            default: return "R6 both";
        endcase
    endfunction

    initial begin
        logic [7:0] rd;
        logic [7:0] vals [4];
        int hits;
        vals[0] = 8'h1B; vals[1] = 8'hE4; vals[2] = 8'h5A; vals[3] = 8'hC3;

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        chk("R1 flags after reset", req_flags, 0);
        for (int p = 0; p < 4; p++) begin
            read_mode(2'(p), rd);
            chk("R1 mode reg after reset", rd, 0);
        end

        // R2: write and read back each port, then disturb one port
        for (int p = 0; p < 4; p++) write_mode(2'(p), vals[p]);
        for (int p = 0; p < 4; p++) begin
            read_mode(2'(p), rd);
            chk("R2 readback", rd, vals[p]);
        end
        write_mode(2'd2, 8'h00);
        for (int p = 0; p < 4; p++) begin
            read_mode(2'(p), rd);
            chk("R2 single port write", rd, (p == 2) ? 8'h00 : vals[p]);
        end
        chk("R12 mode writes on idle lines set nothing", req_flags, 0);
        for (int p = 0; p < 4; p++) write_mode(2'(p), 8'h00);

        // Sweep every pin through every mode code
        for (int pin = 0; pin < 16; pin++) begin
            for (int md = 0; md < 4; md++) begin
                logic [15:0] bitv;
                string tg;
                bitv = 16'(1) << pin;
                tg = mode_tag(md);
                write_mode(2'(pin / 4), 8'(md << (2 * (pin % 4))));
                pulse_clr(16'hFFFF);
                wait_cyc(6);
                chk({tg, " idle high"}, req_flags, 0);
                @(negedge clk); irq_lines[pin] = 1'b0;
                wait_cyc(8);
                chk({tg, " after fall"}, req_flags, (md != 1) ? bitv : 16'h0);
                pulse_clr(bitv);
                wait_cyc(6);
                chk((md == 2) ? "R5 reassert after clear while low" : "R9 clear while low",
                    req_flags, (md == 2) ? bitv : 16'h0);
                @(negedge clk); irq_lines[pin] = 1'b1;
                wait_cyc(8);
                chk((md == 2) ? "R7 level request pending after release" : {tg, " after rise"},
                    req_flags, (md == 0) ? 16'h0 : bitv);
                pulse_ack(4'(pin));
                wait_cyc(6);
                chk("R8 acknowledge clears", req_flags, 0);
                write_mode(2'(pin / 4), 8'h00);
            end
        end

        // R8: acknowledge touches only the indexed flag
        @(negedge clk); irq_lines[5] = 1'b0; irq_lines[6] = 1'b0;
        wait_cyc(8);
        chk("R3 two pins fall", req_flags, 16'h0060);
        pulse_ack(4'd5);
        wait_cyc(2);
        chk("R8 ack only indexed", req_flags, 16'h0040);
        @(negedge clk); irq_lines[5] = 1'b1; irq_lines[6] = 1'b1;
        wait_cyc(6);
        // R9: mask clears only selected bits
        chk("R3 no set on rise", req_flags, 16'h0040);
        pulse_clr(16'hFFBF);
        wait_cyc(2);
        chk("R9 unselected flag kept", req_flags, 16'h0040);
        pulse_clr(16'h0040);
        wait_cyc(2);
        chk("R9 selected flag cleared", req_flags, 16'h0000);

        // R10: single-cycle pulses in consecutive cycles; one sample phase each
        write_mode(2'd0, 8'hAA);
        @(negedge clk); irq_lines[0] = 1'b0;
        @(negedge clk); irq_lines[0] = 1'b1; irq_lines[1] = 1'b0;
        @(negedge clk); irq_lines[1] = 1'b1;
        wait_cyc(8);
        chk("R10 one of two pulses caught", 32'($countones(req_flags[1:0])), 1);
        chk("R10 no other flags", req_flags[15:2], 0);
        pulse_clr(16'hFFFF);
        write_mode(2'd0, 8'h00);

        // R11: clear held across a falling edge; set must win for one cycle
        @(negedge clk); sw_clr = 16'h0004; irq_lines[2] = 1'b0;
        hits = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (req_flags[2]) hits++;
        end
        sw_clr = '0;
        chk("R11 set beats concurrent clear", hits, 1);
        @(negedge clk); irq_lines[2] = 1'b1;
        wait_cyc(6);

        // R12: mode rewrites on a low line do not invent an edge
        @(negedge clk); irq_lines[4] = 1'b0;
        wait_cyc(8);
        pulse_clr(16'h0010);
        write_mode(2'd1, 8'h01);
        write_mode(2'd1, 8'h00);
        write_mode(2'd1, 8'h03);
        write_mode(2'd1, 8'h00);
        wait_cyc(8);
        chk("R12 no flag from mode rewrites", req_flags, 0);
        @(negedge clk); irq_lines[4] = 1'b1;
        wait_cyc(8);
        chk("R3 rise ignored in falling mode", req_flags, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule